// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block raises and retires interrupts between the two ports of a shared dual-port memory. It watches the address, enable and read/write strobes that each port presents to the memory. The two highest word addresses are reserved as mailboxes. The very top word belongs to the right port, and the word just below it belongs to the left port. The message itself stays in the ordinary RAM; this block only keeps the two interrupt flags.

When one port writes the other port's mailbox, the owner's interrupt is raised. When the owner reads its own mailbox, its interrupt is retired. Each port's contention BUSY status from the external arbiter qualifies these accesses. A port whose BUSY is active can neither raise the other port's interrupt nor retire its own. Both flags are active low and are registered, so each takes effect on the clock edge that samples the access.

An access is a write when enable and the write strobe are both high. It is a read when enable and the read strobe are high and the write strobe is low.

Top module: `mbx_irq_top`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `intLeftN` and `intRightN` are both 1 (inactive).
- R2: A left-port write (unbusy) to address all-ones drives `intRightN` to 0 on the clock edge that samples it.
- R3: A right-port write (unbusy) to address all-ones minus one drives `intLeftN` to 0 on the sampling edge.
- R4: An unbusy read by the owner of its own mailbox returns that owner's flag to 1 on the sampling edge. The right port owns all-ones and the left port owns all-ones minus one.
- R5: A port that reads the other port's mailbox leaves that port's flag unchanged.
- R6: A write to the other port's mailbox while the writer's BUSY input is 1 does not set the flag.
- R7: A read of its own mailbox while the owner's BUSY input is 1 does not clear the flag.
- R8: When a set and a clear of the same flag are sampled on the same edge, the flag ends at 0 (the set wins).
- R9: Three kinds of access leave both flags unchanged: accesses with enable low, accesses to any address other than the two mailboxes, and a port writing its own mailbox.
- R10: Once set, a flag stays at 0 through idle cycles until a qualifying clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| leftAddr | input | ADDR_W | Left port word address |
| leftEn | input | 1 | Left port access enable |
| leftWr | input | 1 | Left port write strobe |
| leftRd | input | 1 | Left port read strobe |
| leftBusy | input | 1 | Arbiter BUSY to left port, active high |
| rightAddr | input | ADDR_W | Right port word address |
| rightEn | input | 1 | Right port access enable |
| rightWr | input | 1 | Right port write strobe |
| rightRd | input | 1 | Right port read strobe |
| rightBusy | input | 1 | Arbiter BUSY to right port, active high |
| intLeftN | output | 1 | Interrupt to left port, active low |
| intRightN | output | 1 | Interrupt to right port, active low |

## Verification
Each port writes and reads each mailbox, with BUSY low and then high, so that the test can tell owner accesses from cross accesses and qualified accesses from blocked ones. Near-miss patterns separate true mailbox decodes from accidental ones: the address two below the top, enable low with strobes high, and an owner writing its own box. A cycle in which both ports hit the same mailbox together, one writing and one reading, shows which way a simultaneous set and clear resolves.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  typedef struct packed {
    logic setLeft;
    logic clrLeft;
    logic setRight;
    logic clrRight;
  } mbxStrobes_t;
endpackage

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftEn,
  input  logic              leftWr,
  input  logic              leftRd,
  input  logic              leftBusy,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightEn,
  input  logic              rightWr,
  input  logic              rightRd,
  input  logic              rightBusy,
  output mbxStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] RIGHT_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LEFT_BOX  = RIGHT_BOX - 1'b1;

  logic leftWrite, leftRead, rightWrite, rightRead;

  always_comb begin
    leftWrite  = leftEn && leftWr && !leftBusy;
    leftRead   = leftEn && leftRd && !leftWr && !leftBusy;
    rightWrite = rightEn && rightWr && !rightBusy;
    rightRead  = rightEn && rightRd && !rightWr && !rightBusy;

    strobes.setRight = leftWrite  && (leftAddr  == RIGHT_BOX);
    strobes.clrRight = rightRead  && (rightAddr == RIGHT_BOX);
    strobes.setLeft  = rightWrite && (rightAddr == LEFT_BOX);
    strobes.clrLeft  = leftRead   && (leftAddr  == LEFT_BOX);
  end
endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags
  import mbx_irq_pkg::*;
#(
  parameter int NUM_FLAGS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  mbxStrobes_t strobes,
  output logic        intLeftN,
  output logic        intRightN
);
  logic [NUM_FLAGS-1:0] setVec, clrVec, pending;

  assign setVec = {strobes.setRight, strobes.setLeft};
  assign clrVec = {strobes.clrRight, strobes.clrLeft};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pending[g] <= 1'b0;
      else       pending[g] <= setVec[g] | (pending[g] & ~clrVec[g]);
    end
  end

  assign intLeftN  = ~pending[0];
  assign intRightN = ~pending[1];
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_irq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftEn,
  input  logic              leftWr,
  input  logic              leftRd,
  input  logic              leftBusy,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightEn,
  input  logic              rightWr,
  input  logic              rightRd,
  input  logic              rightBusy,
  output logic              intLeftN,
  output logic              intRightN
);
  mbxStrobes_t strobes;

  mbx_irq_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .leftAddr(leftAddr), .leftEn(leftEn), .leftWr(leftWr), .leftRd(leftRd),
    .leftBusy(leftBusy), .rightAddr(rightAddr), .rightEn(rightEn),
    .rightWr(rightWr), .rightRd(rightRd), .rightBusy(rightBusy),
    .strobes(strobes)
  );

  mbx_irq_flags #(.NUM_FLAGS(2)) i_flags (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .intLeftN(intLeftN), .intRightN(intRightN)
  );
endmodule

// File: rtl/mbx_irq_checker.sv
module mbx_irq_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              leftEn,
  input logic              leftWr,
  input logic              leftRd,
  input logic              leftBusy,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              rightEn,
  input logic              rightWr,
  input logic              rightRd,
  input logic              rightBusy,
  input logic              intLeftN,
  input logic              intRightN
);
  localparam logic [ADDR_W-1:0] TOP  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT = TOP - 1'b1;

  logic rSet, rClr, lSet, lClr;
  assign rSet = leftEn && leftWr && !leftBusy && leftAddr == TOP;
  assign rClr = rightEn && rightRd && !rightWr && !rightBusy && rightAddr == TOP;
  assign lSet = rightEn && rightWr && !rightBusy && rightAddr == NEXT;
  assign lClr = leftEn && leftRd && !leftWr && !leftBusy && leftAddr == NEXT;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (intLeftN && intRightN));
  assert_right_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    rSet |=> !intRightN);
  assert_left_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    lSet |=> !intLeftN);
  assert_right_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rClr && !rSet) |=> intRightN);
  assert_left_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lClr && !lSet) |=> intLeftN);
  assert_right_no_spurious_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intRightN && !rSet) |=> intRightN);
  assert_left_no_spurious_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intLeftN && !lSet) |=> intLeftN);
  assert_right_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!intRightN && !rClr) |=> !intRightN);
  assert_left_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!intLeftN && !lClr) |=> !intLeftN);
endmodule

bind mbx_irq_top mbx_irq_checker #(.ADDR_W(ADDR_W)) i_checker (
  .clk(clk), .rstN(rstN), .leftAddr(leftAddr), .leftEn(leftEn),
  .leftWr(leftWr), .leftRd(leftRd), .leftBusy(leftBusy),
  .rightAddr(rightAddr), .rightEn(rightEn), .rightWr(rightWr),
  .rightRd(rightRd), .rightBusy(rightBusy),
  .intLeftN(intLeftN), .intRightN(intRightN)
);

// File: tb/test_mbx_irq_top.sv
module test_mbx_irq_top;
  localparam int ADDR_W = 15;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [ADDR_W-1:0] TOP  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT = TOP - 1'b1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] leftAddr = '0, rightAddr = '0;
  logic leftEn = 0, leftWr = 0, leftRd = 0, leftBusy = 0;
  logic rightEn = 0, rightWr = 0, rightRd = 0, rightBusy = 0;
  logic intLeftN, intRightN;
  int checkCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_irq_top #(.ADDR_W(ADDR_W)) i_mbx_irq_top (
    .clk(clk), .rstN(rstN),
    .leftAddr(leftAddr), .leftEn(leftEn), .leftWr(leftWr), .leftRd(leftRd),
    .leftBusy(leftBusy), .rightAddr(rightAddr), .rightEn(rightEn),
    .rightWr(rightWr), .rightRd(rightRd), .rightBusy(rightBusy),
    .intLeftN(intLeftN), .intRightN(intRightN)
  );

  task automatic check(string req, logic actual, logic expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b at %0t", req, actual, expected, $time);
    end
  endtask

  // op: 0 none, 1 write, 2 read
  task automatic access(int lOp, logic [ADDR_W-1:0] lA, logic lB, logic lE,
                        int rOp, logic [ADDR_W-1:0] rA, logic rB, logic rE);
    leftAddr = lA; leftEn = lE && (lOp != 0); leftWr = (lOp == 1);
    leftRd = (lOp == 2); leftBusy = lB;
    rightAddr = rA; rightEn = rE && (rOp != 0); rightWr = (rOp == 1);
    rightRd = (rOp == 2); rightBusy = rB;
    if (!lE) begin leftWr = (lOp == 1); leftRd = (lOp == 2); end
    if (!rE) begin rightWr = (rOp == 1); rightRd = (rOp == 2); end
    @(posedge clk);
    @(negedge clk);
    leftEn = 0; leftWr = 0; leftRd = 0; leftBusy = 0;
    rightEn = 0; rightWr = 0; rightRd = 0; rightBusy = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    check("R1 left after reset", intLeftN, 1'b1);
    check("R1 right after reset", intRightN, 1'b1);
  endtask

  task automatic testLeftToRight();
    access(1, TOP, 0, 1, 0, '0, 0, 1);
    check("R2 right set", intRightN, 1'b0);
    check("R2 left untouched", intLeftN, 1'b1);
    idle(3);
    check("R10 right holds", intRightN, 1'b0);
    access(2, TOP, 0, 1, 0, '0, 0, 1);
    check("R5 left reads right box", intRightN, 1'b0);
    access(0, '0, 0, 1, 2, TOP, 1, 1);
    check("R7 busy right read", intRightN, 1'b0);
    access(0, '0, 0, 1, 2, TOP, 0, 0);
    check("R9 right read enable low", intRightN, 1'b0);
    access(0, '0, 0, 1, 2, TOP, 0, 1);
    check("R4 right cleared", intRightN, 1'b1);
  endtask

  task automatic testRightToLeft();
    access(0, '0, 0, 1, 1, NEXT, 0, 1);
    check("R3 left set", intLeftN, 1'b0);
    check("R3 right untouched", intRightN, 1'b1);
    access(0, '0, 0, 1, 2, NEXT, 0, 1);
    check("R5 right reads left box", intLeftN, 1'b0);
    access(2, NEXT, 1, 1, 0, '0, 0, 1);
    check("R7 busy left read", intLeftN, 1'b0);
    access(2, NEXT, 0, 1, 0, '0, 0, 1);
    check("R4 left cleared", intLeftN, 1'b1);
  endtask

  task automatic testBusySet();
    access(1, TOP, 1, 1, 1, NEXT, 1, 1);
    check("R6 busy left write", intRightN, 1'b1);
    check("R6 busy right write", intLeftN, 1'b1);
  endtask

  task automatic testNoEffect();
    access(1, TOP, 0, 0, 1, NEXT, 0, 0);
    check("R9 enable low right", intRightN, 1'b1);
    check("R9 enable low left", intLeftN, 1'b1);
    access(1, TOP - 2, 0, 1, 1, TOP - 2, 0, 1);
    check("R9 other address right", intRightN, 1'b1);
    check("R9 other address left", intLeftN, 1'b1);
    access(1, NEXT, 0, 1, 1, TOP, 0, 1);
    check("R9 own box write left", intLeftN, 1'b1);
    check("R9 own box write right", intRightN, 1'b1);
  endtask

  task automatic testSetWins();
    access(1, TOP, 0, 1, 2, TOP, 0, 1);
    check("R8 right set wins", intRightN, 1'b0);
    access(2, NEXT, 0, 1, 1, NEXT, 0, 1);
    check("R8 left set wins", intLeftN, 1'b0);
    access(2, NEXT, 0, 1, 2, TOP, 0, 1);
    check("R4 both cleared left", intLeftN, 1'b1);
    check("R4 both cleared right", intRightN, 1'b1);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLeftToRight();
    testRightToLeft();
    testBusySet();
    testNoEffect();
    testSetWins();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule